// File: doc/BRIEF.md
# Dataflow Instruction Window with Result Wakeup

This block holds renamed operations between decode and execution. Decode writes at most one operation per cycle into the next free slot of a circular buffer and sees a full flag in return. Each slot stores an opcode and two source operands. A source holds either its value or, until that value exists, the tag of the slot that will produce it, together with a presence bit. A result bus carries a tag and a value. Every waiting source whose tag matches the bus copies the value and becomes present.

Each cycle the window offers at most one ready slot to execution. A slot is ready when it is occupied, has not started, and both of its sources are present. The oldest ready slot wins, measured from the reclaim pointer. The slot index is sent with the operation as its result tag. A completion port marks a slot as no longer in use. A second pointer then reclaims slots strictly in age order, and it stops at the first slot that is still in use.

Top module: `instr_window`

## Requirements
- R1: After a synchronous active-low reset, no operation is offered (`iss_valid` = 0), `in_full` = 0 and `in_slot` = 0.
- R2: When `in_valid` = 1 and `in_full` = 0, the operation is written into slot `in_slot`, and `in_slot` then advances by one modulo DEPTH. When `in_full` = 1, the write is ignored and `in_slot` does not move.
- R3: `in_full` is 1 exactly when DEPTH slots have been allocated and not yet reclaimed.
- R4: `iss_valid` is 1 only when some slot is occupied, not started, and has both sources present. `iss_op`, `iss_a` and `iss_b` then carry that slot's opcode and source values.
- R5: A slot is marked started on the clock edge at which it is offered, and it is never offered again before it is reallocated.
- R6: When several slots are ready, `iss_tag` is the index of the one with the smallest distance from the reclaim pointer (the oldest).
- R7: When `res_valid` = 1, every occupied slot whose source is not present and whose stored tag (the low log2(DEPTH) bits of the source field) equals `res_tag` takes `res_data` and becomes present on that edge. The slot may be offered from the next cycle.
- R8: An operation written with a not-ready source (`in_a_rdy` or `in_b_rdy` = 0, tag in the low bits of the field) in the same cycle as a matching broadcast stores the broadcast value as present.
- R9: `done_valid` with `done_tag` clears the use bit of that slot. The reclaim pointer advances by at most one slot per cycle, and only past a slot whose use bit is clear. A younger slot that completes first does not free space until every older slot has completed.
- R10: A completion that names a slot not in use has no effect on any slot, on the offered operation, or on the full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decode presents an operation |
| in_op | input | OPW | Opcode of the new operation |
| in_a_rdy | input | 1 | Source A holds a value (1) or a tag (0) |
| in_a | input | DW | Source A value, or tag in the low bits |
| in_b_rdy | input | 1 | Source B holds a value (1) or a tag (0) |
| in_b | input | DW | Source B value, or tag in the low bits |
| in_full | output | 1 | No free slot; the new operation is not taken |
| in_slot | output | log2(DEPTH) | Slot that the next accepted operation fills |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | log2(DEPTH) | Tag of the broadcast result |
| res_data | input | DW | Value of the broadcast result |
| iss_valid | output | 1 | An operation is offered to execution this cycle |
| iss_tag | output | log2(DEPTH) | Slot index of the offered operation, used as its result tag |
| iss_op | output | OPW | Opcode of the offered operation |
| iss_a | output | DW | Source A value of the offered operation |
| iss_b | output | DW | Source B value of the offered operation |
| done_valid | input | 1 | Completion of an operation |
| done_tag | input | log2(DEPTH) | Slot index of the completed operation |

## Verification
The window is first filled with operations whose sources are all ready and which never complete. This shows the full flag and an issue order that follows age alone. Out-of-order completions then show that reclaim stops at the oldest busy slot. A directed allocation that coincides with a matching broadcast separates a working bypass from a missed wakeup, and a completion aimed at an idle slot shows that it has no effect. Long random runs then mix value and tag sources, random broadcasts and completions of started slots. In these runs many slots wake at once and wrap around the circle, and the tie-breaking by age is tested from every reclaim pointer position.

// File: rtl/iw_pkg.sv
// Package: default sizes shared by the instruction window modules.
// Assumes: DEPTH is a power of two so slot indices wrap naturally.
package iw_pkg;
    localparam int IW_DEPTH_DEF = 8;
    localparam int IW_OPW_DEF   = 6;
    localparam int IW_DW_DEF    = 16;
endpackage

// File: rtl/iw_operand.sv
// Module: one source field of a slot. Holds a value or a producer tag and
// a presence bit; captures the broadcast result on a tag match, including
// the cycle in which the field is being loaded.
// Assumes: the tag sits in the low TAGW bits of the field while not present.
module iw_operand #(
    parameter int DW   = iw_pkg::IW_DW_DEF,
    parameter int TAGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            load_rdy,
    input  logic [DW-1:0]   load_val,
    input  logic            live,
    input  logic            bc_valid,
    input  logic [TAGW-1:0] bc_tag,
    input  logic [DW-1:0]   bc_data,
    output logic            present,
    output logic [DW-1:0]   val
);
    logic load_hit;
    logic wait_hit;

    // Purpose: detect a broadcast match for the incoming and the stored field.
    always_comb begin
        load_hit = bc_valid && !load_rdy && (load_val[TAGW-1:0] == bc_tag);
        wait_hit = bc_valid && live && !present && (val[TAGW-1:0] == bc_tag);
    end

    // Purpose: hold the field, loading new contents or capturing a wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present <= 1'b0;
            val     <= '0;
        end else if (load) begin
            present <= load_rdy | load_hit;
            val     <= load_hit ? bc_data : load_val;
        end else if (wait_hit) begin
            present <= 1'b1;
            val     <= bc_data;
        end
    end
endmodule

// File: rtl/iw_slot.sv
// Module: one window slot with use and started bits, opcode and two sources.
// Assumes: a load only targets a slot whose use bit is clear.
module iw_slot #(
    parameter int OPW  = iw_pkg::IW_OPW_DEF,
    parameter int DW   = iw_pkg::IW_DW_DEF,
    parameter int TAGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OPW-1:0]  load_op,
    input  logic            load_a_rdy,
    input  logic [DW-1:0]   load_a,
    input  logic            load_b_rdy,
    input  logic [DW-1:0]   load_b,
    input  logic            bc_valid,
    input  logic [TAGW-1:0] bc_tag,
    input  logic [DW-1:0]   bc_data,
    input  logic            issue,
    input  logic            retire,
    output logic            in_use,
    output logic            started,
    output logic            a_present,
    output logic            b_present,
    output logic            ready,
    output logic [OPW-1:0]  op,
    output logic [DW-1:0]   a_val,
    output logic [DW-1:0]   b_val
);
    // Purpose: track occupancy, start status and opcode of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_use  <= 1'b0;
            started <= 1'b0;
            op      <= '0;
        end else if (load) begin
            in_use  <= 1'b1;
            started <= 1'b0;
            op      <= load_op;
        end else begin
            if (retire && in_use) in_use <= 1'b0;
            if (issue) started <= 1'b1;
        end
    end

    iw_operand #(.DW(DW), .TAGW(TAGW)) u_src_a (
        .clk(clk), .rst_n(rst_n), .load(load), .load_rdy(load_a_rdy),
        .load_val(load_a), .live(in_use), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .bc_data(bc_data), .present(a_present), .val(a_val)
    );

    iw_operand #(.DW(DW), .TAGW(TAGW)) u_src_b (
        .clk(clk), .rst_n(rst_n), .load(load), .load_rdy(load_b_rdy),
        .load_val(load_b), .live(in_use), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .bc_data(bc_data), .present(b_present), .val(b_val)
    );

    // Purpose: a slot may go to execution once occupied, idle and complete.
    always_comb ready = in_use && !started && a_present && b_present;
endmodule

// File: rtl/iw_pick.sv
// Module: oldest-first selector. Rotates the request vector so the reclaim
// pointer becomes position zero and takes the lowest set bit.
// Assumes: DEPTH is a power of two.
module iw_pick #(
    parameter int DEPTH = iw_pkg::IW_DEPTH_DEF,
    parameter int TAGW  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [TAGW-1:0]  base,
    output logic             hit,
    output logic [TAGW-1:0]  idx
);
    logic [2*DEPTH-1:0] doubled;
    logic [DEPTH-1:0]   rot;
    logic [TAGW-1:0]    off;

    // Purpose: rotate requests so the oldest slot sits at bit zero.
    always_comb begin
        doubled = {req, req} >> base;
        rot     = doubled[DEPTH-1:0];
    end

    // Purpose: priority-encode the lowest rotated request.
    always_comb begin
        off = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (rot[i]) off = TAGW'(i);
        end
        hit = |rot;
        idx = off + base;
    end
endmodule

// File: rtl/iw_ptrs.sv
// Module: allocation pointer, reclaim pointer and occupancy count.
// Assumes: head_free reports the use bit of the slot at the reclaim pointer.
module iw_ptrs #(
    parameter int DEPTH = iw_pkg::IW_DEPTH_DEF,
    parameter int TAGW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic            head_free,
    output logic            accept,
    output logic            full,
    output logic [TAGW-1:0] alloc_ptr,
    output logic [TAGW-1:0] reclaim_ptr
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ;
    logic          reclaim;

    // Purpose: decide acceptance and in-order reclaim for this cycle.
    always_comb begin
        full    = (occ == CW'(DEPTH));
        accept  = alloc_req && !full;
        reclaim = (occ != '0) && head_free;
    end

    // Purpose: advance pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ         <= '0;
            alloc_ptr   <= '0;
            reclaim_ptr <= '0;
        end else begin
            if (accept)  alloc_ptr   <= alloc_ptr + 1'b1;
            if (reclaim) reclaim_ptr <= reclaim_ptr + 1'b1;
            occ <= occ + CW'(accept) - CW'(reclaim);
        end
    end
endmodule

// File: rtl/instr_window.sv
// Module: dataflow instruction window top. Allocates in order, wakes sources
// from the result bus, offers the oldest ready slot and reclaims in order.
// Assumes: execution tags results with the offered slot index; operands are
// at least TAGW bits wide.
module instr_window #(
    parameter int DEPTH = iw_pkg::IW_DEPTH_DEF,
    parameter int OPW   = iw_pkg::IW_OPW_DEF,
    parameter int DW    = iw_pkg::IW_DW_DEF,
    parameter int TAGW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OPW-1:0]  in_op,
    input  logic            in_a_rdy,
    input  logic [DW-1:0]   in_a,
    input  logic            in_b_rdy,
    input  logic [DW-1:0]   in_b,
    output logic            in_full,
    output logic [TAGW-1:0] in_slot,
    input  logic            res_valid,
    input  logic [TAGW-1:0] res_tag,
    input  logic [DW-1:0]   res_data,
    output logic            iss_valid,
    output logic [TAGW-1:0] iss_tag,
    output logic [OPW-1:0]  iss_op,
    output logic [DW-1:0]   iss_a,
    output logic [DW-1:0]   iss_b,
    input  logic            done_valid,
    input  logic [TAGW-1:0] done_tag
);
    logic                          accept;
    logic [TAGW-1:0]               reclaim_ptr;
    logic [DEPTH-1:0]              use_vec;
    logic [DEPTH-1:0]              exec_vec;
    logic [DEPTH-1:0]              pa_vec;
    logic [DEPTH-1:0]              pb_vec;
    logic [DEPTH-1:0]              rdy_vec;
    logic [DEPTH-1:0][OPW-1:0]     op_arr;
    logic [DEPTH-1:0][DW-1:0]      a_arr;
    logic [DEPTH-1:0][DW-1:0]      b_arr;
    logic [DEPTH-1:0][TAGW-1:0]    a_tag;
    logic [DEPTH-1:0][TAGW-1:0]    b_tag;

    iw_ptrs #(.DEPTH(DEPTH), .TAGW(TAGW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .alloc_req(in_valid),
        .head_free(!use_vec[reclaim_ptr]), .accept(accept), .full(in_full),
        .alloc_ptr(in_slot), .reclaim_ptr(reclaim_ptr)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        iw_slot #(.OPW(OPW), .DW(DW), .TAGW(TAGW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(accept && (in_slot == TAGW'(s))),
            .load_op(in_op), .load_a_rdy(in_a_rdy), .load_a(in_a),
            .load_b_rdy(in_b_rdy), .load_b(in_b),
            .bc_valid(res_valid), .bc_tag(res_tag), .bc_data(res_data),
            .issue(iss_valid && (iss_tag == TAGW'(s))),
            .retire(done_valid && (done_tag == TAGW'(s))),
            .in_use(use_vec[s]), .started(exec_vec[s]),
            .a_present(pa_vec[s]), .b_present(pb_vec[s]), .ready(rdy_vec[s]),
            .op(op_arr[s]), .a_val(a_arr[s]), .b_val(b_arr[s])
        );
        // Purpose: expose the stored producer tags to the checker.
        always_comb begin
            a_tag[s] = a_arr[s][TAGW-1:0];
            b_tag[s] = b_arr[s][TAGW-1:0];
        end
    end

    iw_pick #(.DEPTH(DEPTH), .TAGW(TAGW)) u_pick (
        .req(rdy_vec), .base(reclaim_ptr), .hit(iss_valid), .idx(iss_tag)
    );

    // Purpose: route the chosen slot's contents to the execution side.
    always_comb begin
        iss_op = op_arr[iss_tag];
        iss_a  = a_arr[iss_tag];
        iss_b  = b_arr[iss_tag];
    end
endmodule

// File: rtl/iw_checker.sv
// Module: protocol and ordering checks for the instruction window, bound in.
// Assumes: it observes the top's slot state vectors and reclaim pointer.
module iw_checker #(
    parameter int DEPTH = 8,
    parameter int TAGW  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_full,
    input logic [TAGW-1:0]            in_slot,
    input logic                       res_valid,
    input logic [TAGW-1:0]            res_tag,
    input logic                       iss_valid,
    input logic [TAGW-1:0]            iss_tag,
    input logic [TAGW-1:0]            reclaim_ptr,
    input logic [DEPTH-1:0]           use_vec,
    input logic [DEPTH-1:0]           exec_vec,
    input logic [DEPTH-1:0]           pa_vec,
    input logic [DEPTH-1:0]           pb_vec,
    input logic [DEPTH-1:0][TAGW-1:0] a_tag
);
    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] wait_a;
    logic             older_ready;
    logic             head_busy;

    // Purpose: recompute eligibility, pending wakeups and age ordering.
    always_comb begin
        older_ready = 1'b0;
        head_busy   = use_vec[reclaim_ptr];
        for (int i = 0; i < DEPTH; i++) begin
            elig[i]   = use_vec[i] && !exec_vec[i] && pa_vec[i] && pb_vec[i];
            wait_a[i] = res_valid && use_vec[i] && !pa_vec[i] && (a_tag[i] == res_tag);
            if (elig[i] && (TAGW'(TAGW'(i) - reclaim_ptr) < TAGW'(iss_tag - reclaim_ptr)))
                older_ready = 1'b1;
        end
    end

    assert_slot_stalls_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |=> in_slot == $past(in_slot));

    assert_issue_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> elig[iss_tag]);

    assert_started_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> exec_vec[$past(iss_tag)] && !(iss_valid && iss_tag == $past(iss_tag)));

    assert_oldest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !older_ready);

    assert_wakeup_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wait_a) |=> (($past(wait_a) & ~pa_vec) == '0));

    assert_reclaim_free_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reclaim_ptr != $past(reclaim_ptr)) |-> !$past(head_busy));
endmodule

bind instr_window iw_checker #(.DEPTH(DEPTH), .TAGW(TAGW)) u_iw_checker (
    .clk(clk), .rst_n(rst_n), .in_full(in_full), .in_slot(in_slot),
    .res_valid(res_valid), .res_tag(res_tag), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .reclaim_ptr(reclaim_ptr), .use_vec(use_vec),
    .exec_vec(exec_vec), .pa_vec(pa_vec), .pb_vec(pb_vec), .a_tag(a_tag)
);

// File: tb/tb_instr_window.sv
module tb_instr_window;
    localparam int DEPTH = 8;
    localparam int OPW   = 6;
    localparam int DW    = 16;
    localparam int TAGW  = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid, in_a_rdy, in_b_rdy, res_valid, done_valid;
    logic [OPW-1:0]  in_op;
    logic [DW-1:0]   in_a, in_b, res_data;
    logic [TAGW-1:0] res_tag, done_tag, in_slot, iss_tag;
    logic            in_full, iss_valid;
    logic [OPW-1:0]  iss_op;
    logic [DW-1:0]   iss_a, iss_b;

    int n_chk  = 0;
    int n_fail = 0;
    string cur = "";

    // Reference state of the window
    bit            m_use[DEPTH], m_exec[DEPTH], m_pa[DEPTH], m_pb[DEPTH];
    bit [OPW-1:0]  m_op[DEPTH];
    bit [DW-1:0]   m_a[DEPTH], m_b[DEPTH];
    int            m_aptr, m_dptr, m_occ;

    instr_window #(.DEPTH(DEPTH), .OPW(OPW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a_rdy(in_a_rdy), .in_a(in_a), .in_b_rdy(in_b_rdy), .in_b(in_b),
        .in_full(in_full), .in_slot(in_slot), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data), .iss_valid(iss_valid),
        .iss_tag(iss_tag), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, cur, act, exp);
        end
    endtask

    function automatic int model_pick();
        for (int k = 0; k < DEPTH; k++) begin
            int s = (m_dptr + k) % DEPTH;
            if (m_use[s] && !m_exec[s] && m_pa[s] && m_pb[s]) return s;
        end
        return -1;
    endfunction

    function automatic bit tag_hit(bit rv, bit [TAGW-1:0] rt, bit rdy, bit [DW-1:0] v);
        return rv && !rdy && (v[TAGW-1:0] == rt);
    endfunction

    // Compare outputs with the model, drive one cycle of inputs, advance the model.
    task automatic step(input bit iv, input bit [OPW-1:0] op, input bit ar, input bit [DW-1:0] a,
                        input bit br, input bit [DW-1:0] b, input bit rv, input bit [TAGW-1:0] rt,
                        input bit [DW-1:0] rd, input bit dv, input bit [TAGW-1:0] dt);
        int pk;
        pk = model_pick();
        chk("R4", iss_valid, pk >= 0);
        if (pk >= 0) begin
            chk("R6", iss_tag, pk);
            chk("R4", iss_op, m_op[pk]);
            chk("R7", iss_a, m_a[pk]);
            chk("R7", iss_b, m_b[pk]);
        end
        chk("R3", in_full, m_occ == DEPTH);
        chk("R2", in_slot, m_aptr);
        in_valid = iv; in_op = op; in_a_rdy = ar; in_a = a; in_b_rdy = br; in_b = b;
        res_valid = rv; res_tag = rt; res_data = rd; done_valid = dv; done_tag = dt;
        // model next state, using the current state throughout
        begin
            bit head_free = (m_occ > 0) && !m_use[m_dptr];
            bit acc = iv && (m_occ < DEPTH);
            if (head_free) begin m_dptr = (m_dptr + 1) % DEPTH; m_occ--; end
            if (dv && m_use[dt]) m_use[dt] = 1'b0;
            for (int s = 0; s < DEPTH; s++) begin
                if (m_use[s] && tag_hit(rv, rt, m_pa[s], m_a[s])) begin m_pa[s] = 1; m_a[s] = rd; end
                if (m_use[s] && tag_hit(rv, rt, m_pb[s], m_b[s])) begin m_pb[s] = 1; m_b[s] = rd; end
            end
            if (pk >= 0) m_exec[pk] = 1'b1;
            if (acc) begin
                m_use[m_aptr] = 1; m_exec[m_aptr] = 0; m_op[m_aptr] = op;
                m_pa[m_aptr] = ar || tag_hit(rv, rt, ar, a);
                m_a[m_aptr]  = tag_hit(rv, rt, ar, a) ? rd : a;
                m_pb[m_aptr] = br || tag_hit(rv, rt, br, b);
                m_b[m_aptr]  = tag_hit(rv, rt, br, b) ? rd : b;
                m_aptr = (m_aptr + 1) % DEPTH; m_occ++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        in_valid = 0; in_op = 0; in_a_rdy = 0; in_a = 0; in_b_rdy = 0; in_b = 0;
        res_valid = 0; res_tag = 0; res_data = 0; done_valid = 0; done_tag = 0;
        for (int s = 0; s < DEPTH; s++) begin
            m_use[s] = 0; m_exec[s] = 0; m_pa[s] = 0; m_pb[s] = 0;
            m_op[s] = 0; m_a[s] = 0; m_b[s] = 0;
        end
        m_aptr = 0; m_dptr = 0; m_occ = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur = "R1 reset";
        chk("R1", iss_valid, 0);
        chk("R1", in_full, 0);
        chk("R1", in_slot, 0);

        // R3/R6: fill with ready operations, one extra write is refused while full
        cur = "R3 fill";
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 6'(i + 1), 1, 16'(16'h100 + i), 1, 16'(16'h200 + i), 0, 0, 0, 0, 0);
        cur = "R5 drained";
        idle(DEPTH);
        chk("R5", iss_valid, 0);
        // R9: younger completion first does not free space
        cur = "R9 out of order";
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
        idle(3);
        chk("R9", in_full, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle(2);
        chk("R9", in_full, 0);
        for (int i = 1; i < DEPTH; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'(i));
        idle(DEPTH + 2);

        // R8: allocation of a waiting source coinciding with its broadcast
        cur = "R8 bypass";
        step(1, 6'h2a, 0, 16'h0005, 1, 16'h0077, 1, 3'd5, 16'hbeef, 0, 0);
        chk("R8", iss_valid, 1);
        chk("R8", iss_a, 16'hbeef);
        // R7: waiting source woken later
        cur = "R7 wakeup";
        step(1, 6'h15, 1, 16'h0011, 0, 16'h0002, 0, 0, 0, 0, 0);
        idle(2);
        step(0, 0, 0, 0, 0, 0, 1, 3'd2, 16'h1234, 0, 0);
        chk("R7", iss_b, 16'h1234);
        idle(2);

        // R10: completion naming an idle slot
        cur = "R10 idle completion";
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'(m_aptr + 3));
        idle(2);
        chk("R10", in_full, 0);

        // random traffic
        cur = "random";
        for (int c = 0; c < 6000; c++) begin
            bit ar = $urandom_range(0, 1);
            bit br = $urandom_range(0, 1);
            bit dv = 0;
            bit [TAGW-1:0] dt = 0;
            int start = $urandom_range(0, DEPTH - 1);
            if ($urandom_range(0, 1)) begin
                for (int k = 0; k < DEPTH; k++) begin
                    int s = (start + k) % DEPTH;
                    if (!dv && m_use[s] && m_exec[s]) begin dv = 1; dt = 3'(s); end
                end
            end else if ($urandom_range(0, 15) == 0) begin
                dv = 1; dt = 3'(start);
            end
            step($urandom_range(0, 2) != 0, 6'($urandom), ar, 16'($urandom), br, 16'($urandom),
                 $urandom_range(0, 4) < 2, 3'($urandom), 16'($urandom), dv, dt);
        end
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule